// File: doc/BRIEF.md
# CAN Receive Bit Sampler with Stuff-Bit Removal

This block sits at the front of a CAN receiver. It watches the single receive line, synchronous to a fast system clock, and waits for the line to go dominant (logic 0). That clock cycle becomes the timing reference for the whole frame. Every later bit is sampled at an absolute cycle count measured from that reference. The count is the raw bit index times the configured bit width, plus a sample-point offset. There is no resynchronisation on later edges, so timing never drifts relative to the reference.

Each sampled bit passes through a run-length tracker. After five identical raw bits, the next bit of opposite value is a stuff bit. It is reported on a separate strobe together with its sampled value and is not forwarded. A sixth identical bit is flagged as a stuffing error. All other bits go to the downstream frame parser on a valid strobe.

The parser drives two controls. The first marks the end of the checksum sequence, which turns stuffing off for the unstuffed tail of the frame. The second is a restart pulse that sends the block back to idle for the next frame.

Top module: `can_bit_sampler`

## Requirements
- R1: While idle, a recessive receive line (1) produces no strobe. The first clock cycle in which the line is seen dominant (0) is the frame reference, and that cycle counts as cycle 0.
- R2: Raw bit n is sampled in the cycle whose count since the reference equals n × `bit_cycles_i` + `sample_off_i`, with 0 < `sample_off_i` < `bit_cycles_i`. Its strobe appears on the outputs one clock later.
- R3: The package function `pct_to_cycles(bw, pct)` turns a sample point given in percent into a cycle offset, floor(bw × pct / 100). The package defaults are 50 cycles per bit (1 Mbit/s at 50 MHz) with a 70 % sample point, which gives 35 cycles.
- R4: While stuffing is on, a raw bit that follows five identical raw bits and differs from them is a stuff bit. It raises `stuff_vld_o` for one cycle with `stuff_bit_o` equal to its value, and it does not raise `frame_bit_vld_o`.
- R5: A stuff bit uses one raw bit slot, so it shifts the sample instant of every later bit by one bit width.
- R6: After a stuff bit, the run count restarts at the stuff bit itself: the stuff bit plus four more equal bits make the next run of five.
- R7: While stuffing is on, a sixth identical raw bit raises `stuff_err_o` for one cycle and is not forwarded. The run count then restarts from that bit.
- R8: A `crc_end_i` pulse turns stuffing off from the cycle in which it is high until the next restart. While stuffing is off, every sampled bit is forwarded as a frame bit, whatever the run length.
- R9: `restart_i` returns the block to idle and clears the run history and the stuffing-off state. A sample that falls in the same cycle as the restart is dropped.
- R10: Each non-stuff bit is presented as `frame_bit_o` with a one-cycle `frame_bit_vld_o`, in arrival order, with the start-of-frame bit first. At most one of the three strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Bus receive line, 0 = dominant |
| bit_cycles_i | input | CFG_W | Clock cycles per bit time |
| sample_off_i | input | CFG_W | Sample-point offset inside a bit, in cycles |
| crc_end_i | input | 1 | Pulse from the parser: checksum sequence finished, stop destuffing |
| restart_i | input | 1 | Pulse from the parser: frame done, return to idle |
| frame_bit_vld_o | output | 1 | Strobe for a forwarded frame bit |
| frame_bit_o | output | 1 | Value of the forwarded frame bit |
| stuff_vld_o | output | 1 | Strobe for a removed stuff bit |
| stuff_bit_o | output | 1 | Sampled value of the removed stuff bit |
| stuff_err_o | output | 1 | Strobe for a sixth identical bit while stuffing is on |

## Verification
Two events can land in the same cycle: a parser control (`crc_end_i` or `restart_i`) and the sample strobe of a bit. The bench drives each control in exactly the cycle that samples a chosen raw bit. In one frame the `crc_end_i` pulse lands on a bit that would otherwise be a stuff bit, and in another it lands on a sixth identical bit. Both bits must come out as ordinary frame bits, with no stuff or error strobe. In the restart case, the bench counts the forwarded bits and requires that the coinciding sample is not among them.

// File: rtl/can_samp_pkg.sv
package can_samp_pkg;

    localparam int CFG_W        = 12;
    localparam int TIME_W       = 20;
    localparam int STUFF_RUN    = 5;
    localparam int DEF_CLK_HZ   = 50_000_000;
    localparam int DEF_BITRATE  = 1_000_000;
    localparam int DEF_SP_PCT   = 70;
    localparam int DEF_BIT_CYCLES = DEF_CLK_HZ / DEF_BITRATE;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    // one raw sample offered to the destuffer
    typedef struct packed {
        logic vld;
        logic val;
    } raw_smp_t;

    // registered result of one sample
    typedef struct packed {
        logic frame_vld;
        logic frame_val;
        logic stuff_vld;
        logic stuff_val;
        logic stuff_err;
    } dstf_out_t;

    function automatic logic [CFG_W-1:0] pct_to_cycles(input logic [CFG_W-1:0] bw,
                                                       input int unsigned pct);
        int unsigned prod;
        prod = int'(bw) * pct;
        return CFG_W'(prod / 100);
    endfunction

endpackage

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_samp_pkg::*;
#(
    parameter int P_CFG_W  = CFG_W,
    parameter int P_TIME_W = TIME_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart_i,
    input  logic               rx_i,
    input  logic [P_CFG_W-1:0] bit_cycles_i,
    input  logic [P_CFG_W-1:0] sample_off_i,
    output raw_smp_t           smp_o
);

    tmr_state_e          state_q;
    logic [P_TIME_W-1:0] cnt_q;
    logic [P_TIME_W-1:0] tgt_q;
    logic                hit;

    // absolute target: reference + n*width + offset, no resync
    assign hit       = (state_q == TMR_RUN) && (cnt_q == tgt_q) && !restart_i;
    assign smp_o.vld = hit;
    assign smp_o.val = rx_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            state_q <= TMR_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
        end else begin
            case (state_q)
                TMR_IDLE: begin
                    if (!rx_i) begin
                        state_q <= TMR_RUN;
                        cnt_q   <= P_TIME_W'(1);
                        tgt_q   <= P_TIME_W'(sample_off_i);
                    end
                end
                default: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (hit)
                        tgt_q <= tgt_q + P_TIME_W'(bit_cycles_i);
                end
            endcase
        end
    end

    // R1: a dominant level while idle starts the frame timer
    assert_sof_start_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == TMR_IDLE && !rx_i && !restart_i) |=> (state_q == TMR_RUN && cnt_q == P_TIME_W'(1)));

    // R2: two sample strobes never sit back to back when a bit spans several cycles
    assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        (smp_o.vld && bit_cycles_i > P_CFG_W'(1)) |=> !smp_o.vld);

endmodule

// File: rtl/can_destuffer.sv
module can_destuffer
    import can_samp_pkg::*;
#(
    parameter int P_STUFF_RUN = STUFF_RUN
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart_i,
    input  logic      crc_end_i,
    input  raw_smp_t  smp_i,
    output dstf_out_t out_o
);

    localparam int RUN_W = $clog2(P_STUFF_RUN + 1);

    logic [RUN_W-1:0] run_q;
    logic             last_q;
    logic             off_q;
    dstf_out_t        out_q;
    dstf_out_t        out_d;

    logic at_limit, stuff_on, same, is_stuff, is_err;
    logic [RUN_W-1:0] run_d;
    logic             last_d;

    assign at_limit = (run_q == RUN_W'(P_STUFF_RUN));
    assign stuff_on = !off_q && !crc_end_i;
    assign same     = (run_q != '0) && (smp_i.val == last_q);
    assign is_stuff = smp_i.vld && stuff_on && at_limit && !same;
    assign is_err   = smp_i.vld && stuff_on && at_limit && same;

    always_comb begin
        run_d  = run_q;
        last_d = last_q;
        if (smp_i.vld) begin
            last_d = smp_i.val;
            if (is_stuff || is_err)
                run_d = RUN_W'(1);
            else if (same)
                run_d = at_limit ? run_q : run_q + 1'b1;
            else
                run_d = RUN_W'(1);
        end
        out_d.frame_vld = smp_i.vld && !is_stuff && !is_err;
        out_d.frame_val = smp_i.val;
        out_d.stuff_vld = is_stuff;
        out_d.stuff_val = smp_i.val;
        out_d.stuff_err = is_err;
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            run_q  <= '0;
            last_q <= 1'b1;
            off_q  <= 1'b0;
            out_q  <= '0;
        end else begin
            run_q  <= run_d;
            last_q <= last_d;
            off_q  <= off_q || crc_end_i;
            out_q  <= out_d;
        end
    end

    assign out_o = out_q;

    // R10: the three strobes are mutually exclusive
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_q.frame_vld, out_q.stuff_vld, out_q.stuff_err}));

    // R8: once stuffing is off, no stuff or error strobe until restart
    assert_stuff_off_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (off_q && !restart_i) |=> (off_q && !out_q.stuff_vld && !out_q.stuff_err));

    // R7: an error strobe only follows a full run
    assert_err_after_run_R7: assert property (@(posedge clk) disable iff (rst)
        out_q.stuff_err |-> ($past(run_q) == RUN_W'(P_STUFF_RUN)));

    // R9: restart clears the history and silences the outputs
    assert_restart_clear_R9: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (run_q == '0 && !off_q && !out_q.frame_vld && !out_q.stuff_vld));

endmodule

// File: rtl/can_bit_sampler.sv
module can_bit_sampler
    import can_samp_pkg::*;
#(
    parameter int P_CFG_W     = CFG_W,
    parameter int P_TIME_W    = TIME_W,
    parameter int P_STUFF_RUN = STUFF_RUN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_i,
    input  logic [P_CFG_W-1:0] bit_cycles_i,
    input  logic [P_CFG_W-1:0] sample_off_i,
    input  logic               crc_end_i,
    input  logic               restart_i,
    output logic               frame_bit_vld_o,
    output logic               frame_bit_o,
    output logic               stuff_vld_o,
    output logic               stuff_bit_o,
    output logic               stuff_err_o
);

    raw_smp_t  smp;
    dstf_out_t dout;

    can_bit_timer #(
        .P_CFG_W  (P_CFG_W),
        .P_TIME_W (P_TIME_W)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .restart_i    (restart_i),
        .rx_i         (rx_i),
        .bit_cycles_i (bit_cycles_i),
        .sample_off_i (sample_off_i),
        .smp_o        (smp)
    );

    can_destuffer #(
        .P_STUFF_RUN (P_STUFF_RUN)
    ) u_destuff (
        .clk       (clk),
        .rst       (rst),
        .restart_i (restart_i),
        .crc_end_i (crc_end_i),
        .smp_i     (smp),
        .out_o     (dout)
    );

    assign frame_bit_vld_o = dout.frame_vld;
    assign frame_bit_o     = dout.frame_val;
    assign stuff_vld_o     = dout.stuff_vld;
    assign stuff_bit_o     = dout.stuff_val;
    assign stuff_err_o     = dout.stuff_err;

    // R2: every output strobe is the registered result of a timer sample one cycle earlier
    assert_out_follows_sample_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_bit_vld_o || stuff_vld_o || stuff_err_o) |-> $past(smp.vld));

endmodule

// File: tb/can_bit_sampler_tb.sv
module can_bit_sampler_tb_top;
    import can_samp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int BW         = 8;
    localparam int SP_PCT     = 70;
    localparam int OFF        = (BW * SP_PCT) / 100;   // 5
    localparam int NV         = 8;

    typedef struct packed {
        logic [31:0] raw;      // first raw bit at bit 31
        logic [7:0]  n;
        logic [7:0]  crc_idx;  // 8'hFF = no crc_end pulse
        logic [15:0] fb;       // expected frame bits, right aligned
        logic [7:0]  fn;
        logic [7:0]  nst;
        logic [7:0]  nerr;
        logic        sv;
        logic [7:0]  sidx;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{32'h4000_0000, 8'd7,  8'hFF, 16'h0020, 8'd7,  8'd0, 8'd0, 1'b0, 8'd0},
        '{32'h5A60_0000, 8'd12, 8'hFF, 16'h05A6, 8'd12, 8'd0, 8'd0, 1'b0, 8'd0},
        '{32'h0580_0000, 8'd10, 8'hFF, 16'h0006, 8'd9,  8'd1, 8'd0, 1'b1, 8'd5},
        '{32'h07C8_0000, 8'd13, 8'hFF, 16'h003D, 8'd11, 8'd2, 8'd0, 1'b0, 8'd10},
        '{32'h0300_0000, 8'd8,  8'hFF, 16'h0003, 8'd7,  8'd0, 8'd1, 1'b0, 8'd0},
        '{32'h2810_0000, 8'd12, 8'd10, 16'h0281, 8'd12, 8'd0, 8'd0, 1'b0, 8'd0},
        '{32'h2830_0000, 8'd12, 8'd10, 16'h0283, 8'd12, 8'd0, 8'd0, 1'b0, 8'd0},
        '{32'h6080_0000, 8'd10, 8'd2,  16'h0182, 8'd10, 8'd0, 8'd0, 1'b0, 8'd0}
    };
    localparam string VTAG [NV] = '{"R10", "R9", "R4", "R6", "R7", "R8", "R8", "R8"};

    logic clk = 1'b0;
    logic rst, rx, crc_end, restart;
    logic fvld, fbit, svld, sbit, serr;
    int   n_checks = 0;
    int   n_fail   = 0;
    logic done     = 1'b0;

    int          r_fn, r_nst, r_nerr, r_first, r_srel;
    logic [31:0] r_fb;
    logic        r_sv;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_sampler dut_i (
        .clk             (clk),
        .rst             (rst),
        .rx_i            (rx),
        .bit_cycles_i    (CFG_W'(BW)),
        .sample_off_i    (CFG_W'(OFF)),
        .crc_end_i       (crc_end),
        .restart_i       (restart),
        .frame_bit_vld_o (fvld),
        .frame_bit_o     (fbit),
        .stuff_vld_o     (svld),
        .stuff_bit_o     (sbit),
        .stuff_err_o     (serr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive one raw stream; restart pulses at end (or inside at rst_idx)
    task automatic drive_frame(input logic [31:0] raw, input int n,
                               input int crc_idx, input int rst_idx);
        r_fn = 0; r_nst = 0; r_nerr = 0; r_first = -1; r_srel = -1;
        r_fb = '0; r_sv = 1'b0;
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < BW; c++) begin
                rx      = raw[31-i];
                crc_end = (i == crc_idx) && (c == OFF);
                restart = (i == rst_idx) && (c == OFF);
                @(negedge clk);
                if (fvld) begin
                    r_fb = {r_fb[30:0], fbit};
                    r_fn++;
                    if (r_first < 0) r_first = i*BW + c + 1;
                end
                if (svld) begin
                    r_nst++;
                    r_sv   = sbit;
                    r_srel = i*BW + c + 1;
                end
                if (serr) r_nerr++;
            end
        end
        crc_end = 1'b0;
        rx      = 1'b1;
        restart = 1'b1;
        @(negedge clk);
        restart = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int quiet;
        rst = 1'b1; rx = 1'b1; crc_end = 1'b0; restart = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!fvld && !svld && !serr, "R1", "outputs after reset",
              {fvld, svld, serr}, 0);

        // R1: recessive idle line yields nothing
        quiet = 0;
        repeat (40) begin
            @(negedge clk);
            if (fvld || svld || serr) quiet++;
        end
        check(quiet == 0, "R1", "strobes on idle line", quiet, 0);

        // R3: percentage to cycle conversion
        check(int'(pct_to_cycles(CFG_W'(DEF_BIT_CYCLES), DEF_SP_PCT)) == 35,
              "R3", "default offset", int'(pct_to_cycles(CFG_W'(DEF_BIT_CYCLES), DEF_SP_PCT)), 35);
        check(int'(pct_to_cycles(CFG_W'(BW), SP_PCT)) == OFF, "R3", "bench offset",
              int'(pct_to_cycles(CFG_W'(BW), SP_PCT)), OFF);

        for (int v = 0; v < NV; v++) begin
            drive_frame(VECS[v].raw, int'(VECS[v].n),
                        (VECS[v].crc_idx == 8'hFF) ? -1 : int'(VECS[v].crc_idx), -1);
            check(r_fn == int'(VECS[v].fn), VTAG[v], "frame bit count", r_fn, int'(VECS[v].fn));
            check(r_fb == {16'h0, VECS[v].fb}, VTAG[v], "frame bits", int'(r_fb), int'(VECS[v].fb));
            check(r_nst == int'(VECS[v].nst), "R4", "stuff count", r_nst, int'(VECS[v].nst));
            check(r_nerr == int'(VECS[v].nerr), "R7", "error count", r_nerr, int'(VECS[v].nerr));
            check(r_first == 1 + OFF, "R2", "first strobe cycle", r_first, 1 + OFF);
            if (VECS[v].nst != 0) begin
                check(r_sv == VECS[v].sv, "R4", "stuff value", int'(r_sv), int'(VECS[v].sv));
                check(r_srel == 1 + int'(VECS[v].sidx)*BW + OFF, "R5", "stuff strobe cycle",
                      r_srel, 1 + int'(VECS[v].sidx)*BW + OFF);
            end
        end

        // R9: restart in the sample cycle of raw bit 3 drops that bit and all after
        drive_frame(32'h7F80_0000, 8, -1, 3);
        check(r_fn == 3, "R9", "bits before coinciding restart", r_fn, 3);
        check(r_nst == 0 && r_nerr == 0, "R9", "events after restart", r_nst + r_nerr, 0);

        // R9: a clean frame after that restart
        drive_frame(32'h5000_0000, 4, -1, -1);
        check(r_fb == 32'h5 && r_fn == 4, "R9", "frame after restart", int'(r_fb), 5);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule